// File: doc/BRIEF.md
# Converter Power Sequencing Controller

This block steps an audio digital-to-analog converter from its reset condition to live audio and back again. Six states make up the sequence: reset, power-down, initialization, power-up, normal operation and mute. Arrival of the master clock, and then of valid frame and bit clocks with a legal clock ratio, moves the machine forward. Timers alone never do. Inside power-up, a gap counter switches on the filter and modulator, the reference, the output-clamp release and the output amplifier in that fixed order. A fixed number of master-clock cycles separates each step.

A low functional reset, or an asserted power-good reset, returns the machine to reset from any state. If the master clock disappears, the machine falls back to power-down. A ratio change while audio is live enters mute with all supplies held, and a legal ratio brings audio back. A separate counter tracks consecutive zero-valued input samples. It raises a flag once the run is long enough for shutdown to be pop-free.

All inputs are synchronous to `clk`. `rst_n` initialises the flops.

Top module: `dac_pwr_seq`

## Requirements
- R1: `state_o` uses these codes: 0 reset, 1 power-down, 2 initialization, 3 power-up, 4 normal, 5 mute. If `ext_rst_n` is low or `por_rst` is high at a clock edge, the state after that edge is reset, whatever the current state. In reset, `ref_tie`, `out_clamp` and `mute` are 1, and `cp_en`, `filt_en`, `ref_up` and `amp_en` are 0.
- R2: From reset, once both reset inputs are inactive, the next state is power-down. Power-down holds while `mclk_ok` is low, with every enable at 0, `out_clamp` at 1 and `ref_tie` at 0.
- R3: In power-down, `mclk_ok` high moves the machine to initialization on the next edge. `cp_en` is 1 in initialization, and the other three enables stay 0.
- R4: Initialization holds until `clocks_ok` and `ratio_ok` are both high, and then enters power-up on the next edge.
- R5: Power-up takes four steps, each `GAP_CYC` cycles long. The first state cycle of power-up counts as cycle 0. `filt_en` rises after `GAP_CYC` cycles, `ref_up` after 2·`GAP_CYC`, `out_clamp` falls after 3·`GAP_CYC`, and `amp_en` rises after 4·`GAP_CYC`. Normal operation begins one cycle after `amp_en` rises.
- R6: `mute` is 0 only in normal operation. In normal operation and in mute, all four enables are 1 and `out_clamp` is 0.
- R7: In normal operation, a `ratio_chg` pulse or a low `ratio_ok` moves the machine to mute on the next edge, and the enables do not change.
- R8: In mute, `ratio_ok` high with `ratio_chg` low returns the machine to normal operation on the next edge. Otherwise it stays in mute.
- R9: In initialization, power-up, normal or mute, a low `mclk_ok` moves the machine to power-down on the next edge. There, every enable is 0 and `out_clamp` is 1.
- R10: Suppose all clocks are valid and `ratio_ok` is high when the resets are released. Then normal operation is reached exactly 4·`GAP_CYC`+4 edges after release, which must stay below `MAX_START_CYC`.
- R11: `zeros_ok` becomes 1 after the edge that accepts the `ZERO_RUN`-th consecutive zero sample (`sample_valid` high, `sample_data` all zero). A valid nonzero sample clears the run and the flag on its edge. Cycles with `sample_valid` low change neither.
- R12: When events coincide, reset wins over master-clock loss, and master-clock loss wins over a ratio event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock domain clock |
| rst_n | input | 1 | Asynchronous flop initialisation, active low |
| ext_rst_n | input | 1 | Functional reset from a pin, active low |
| por_rst | input | 1 | Power-good reset, active high |
| mclk_ok | input | 1 | Master clock present |
| clocks_ok | input | 1 | Frame and bit clocks valid |
| ratio_ok | input | 1 | Legal master-clock to frame ratio detected |
| ratio_chg | input | 1 | One-cycle pulse: detected ratio changed |
| sample_valid | input | 1 | `sample_data` carries a sample this cycle |
| sample_data | input | SAMPLE_W | Two's complement input sample |
| state_o | output | 3 | Current sequence state code |
| cp_en | output | 1 | Charge pump enable |
| filt_en | output | 1 | Filter and modulator enable |
| ref_up | output | 1 | Reference raised to operating level |
| out_clamp | output | 1 | Weak output pull-down to ground |
| amp_en | output | 1 | Output amplifier power |
| ref_tie | output | 1 | Reference node tied to supply |
| mute | output | 1 | Audio muted |
| zeros_ok | output | 1 | Zero-sample run long enough for shutdown |

## Verification
In normal operation, a ratio event and master-clock loss can arrive in the same cycle. Both try to leave normal operation, but toward different states. The bench drives `ratio_chg` high and `mclk_ok` low on the same edge and expects power-down with the amplifier off, not mute. In a second case, the bench drops `ext_rst_n` and `mclk_ok` together and expects reset, with `ref_tie` high.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_PDN   = 3'd1,
        ST_INIT  = 3'd2,
        ST_PUP   = 3'd3,
        ST_NORM  = 3'd4,
        ST_MUTE  = 3'd5
    } seq_state_e;

    // power-up steps in order: filter, reference, clamp release, amplifier
    localparam int unsigned N_STEPS    = 4;
    localparam int unsigned STEP_FILT  = 0;
    localparam int unsigned STEP_REF   = 1;
    localparam int unsigned STEP_CLAMP = 2;
    localparam int unsigned STEP_AMP   = 3;

endpackage

// File: rtl/dac_pup_stepper.sv
module dac_pup_stepper #(
    parameter int unsigned GAP_CYC = 8,
    parameter int unsigned NSTEP   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [NSTEP-1:0] step_en,
    output logic             done
);
    localparam int unsigned GW = $clog2(GAP_CYC + 1);
    localparam int unsigned SW = $clog2(NSTEP + 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
    localparam logic [SW-1:0] STAGE_END = SW'(NSTEP);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [SW-1:0] stage;
    } step_t;

    step_t d, q;

    always_comb begin
        d = q;
        if (!run) begin
            d = '0;
        end else if (q.stage != STAGE_END) begin
            if (q.gap == GAP_LAST) begin
                d.gap   = '0;
                d.stage = q.stage + 1'b1;
            end else begin
                d.gap = q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar k = 0; k < NSTEP; k++) begin : g_step
        assign step_en[k] = (q.stage > SW'(k));
    end

    assign done = (q.stage == STAGE_END);

    // R5: stages never go backwards while power-up runs
    p_stage_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || q.stage >= $past(q.stage)));

    // R5: a later step is never on without the earlier one
    p_step_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en[NSTEP-1] |-> step_en[0]);

endmodule

// File: rtl/dac_zero_run.sv
module dac_zero_run #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned ZERO_RUN = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic                zeros_ok
);
    localparam int unsigned CW = $clog2(ZERO_RUN + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(ZERO_RUN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_t;

    run_t d, q;

    always_comb begin
        d = q;
        if (sample_valid) begin
            if (sample_data != '0)      d.cnt = '0;
            else if (q.cnt != RUN_MAX)  d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign zeros_ok = (q.cnt == RUN_MAX);

    p_nonzero_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_data != '0) |=> !zeros_ok);

    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(zeros_ok));

    p_rise_on_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zeros_ok) |-> ($past(sample_valid) && $past(sample_data) == '0));

endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
    import dac_seq_pkg::*;
#(
    parameter int unsigned GAP_CYC       = 8,
    parameter int unsigned MAX_START_CYC = 64,
    parameter int unsigned SAMPLE_W      = 24,
    parameter int unsigned ZERO_RUN      = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_rst_n,
    input  logic                por_rst,
    input  logic                mclk_ok,
    input  logic                clocks_ok,
    input  logic                ratio_ok,
    input  logic                ratio_chg,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic [2:0]          state_o,
    output logic                cp_en,
    output logic                filt_en,
    output logic                ref_up,
    output logic                out_clamp,
    output logic                amp_en,
    output logic                ref_tie,
    output logic                mute,
    output logic                zeros_ok
);
    localparam int unsigned BW = $clog2(MAX_START_CYC + 1);

    typedef struct packed {
        seq_state_e st;
    } ctl_t;

    ctl_t d, q;
    logic               any_rst;
    logic               pup_run;
    logic               pup_done;
    logic [N_STEPS-1:0] step_en;
    logic [N_STEPS-1:0] rail_on;
    logic               live;

    assign any_rst = !ext_rst_n || por_rst;

    // next-state logic: reset, then clock loss, then ratio events
    always_comb begin
        d = q;
        if (any_rst) begin
            d.st = ST_RESET;
        end else begin
            unique case (q.st)
                ST_RESET: d.st = ST_PDN;
                ST_PDN:   if (mclk_ok) d.st = ST_INIT;
                ST_INIT: begin
                    if (!mclk_ok)                    d.st = ST_PDN;
                    else if (clocks_ok && ratio_ok)  d.st = ST_PUP;
                end
                ST_PUP: begin
                    if (!mclk_ok)      d.st = ST_PDN;
                    else if (pup_done) d.st = ST_NORM;
                end
                ST_NORM: begin
                    if (!mclk_ok)                     d.st = ST_PDN;
                    else if (ratio_chg || !ratio_ok)  d.st = ST_MUTE;
                end
                ST_MUTE: begin
                    if (!mclk_ok)                     d.st = ST_PDN;
                    else if (ratio_ok && !ratio_chg)  d.st = ST_NORM;
                end
                default: d.st = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RESET};
        else        q <= d;
    end

    assign pup_run = (q.st == ST_PUP);

    dac_pup_stepper #(
        .GAP_CYC (GAP_CYC),
        .NSTEP   (N_STEPS)
    ) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pup_run),
        .step_en (step_en),
        .done    (pup_done)
    );

    assign live = (q.st == ST_NORM) || (q.st == ST_MUTE);

    for (genvar k = 0; k < N_STEPS; k++) begin : g_rail
        assign rail_on[k] = live || (pup_run && step_en[k]);
    end

    assign state_o   = q.st;
    assign cp_en     = (q.st == ST_INIT) || pup_run || live;
    assign filt_en   = rail_on[STEP_FILT];
    assign ref_up    = rail_on[STEP_REF];
    assign out_clamp = !rail_on[STEP_CLAMP];
    assign amp_en    = rail_on[STEP_AMP];
    assign ref_tie   = (q.st == ST_RESET);
    assign mute      = (q.st != ST_NORM);

    dac_zero_run #(
        .SAMPLE_W (SAMPLE_W),
        .ZERO_RUN (ZERO_RUN)
    ) u_zero (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .zeros_ok     (zeros_ok)
    );

    // ---------------- assertions ----------------
    p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> (state_o == ST_RESET && ref_tie && out_clamp && !amp_en));

    p_pdn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PDN && !mclk_ok && !any_rst) |=> (state_o == ST_PDN && !cp_en));

    p_init_cp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PDN && mclk_ok && !any_rst) |=> (cp_en && !filt_en));

    p_clamp_after_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_clamp |-> (ref_up && filt_en && cp_en));

    p_amp_after_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        amp_en |-> !out_clamp);

    p_ratio_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORM && ratio_chg && mclk_ok && !any_rst)
            |=> (state_o == ST_MUTE && mute && amp_en));

    p_mclk_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_RESET && !mclk_ok && !any_rst) |=> (state_o == ST_PDN && !amp_en));

    // R10: bounded bring-up with valid clocks, watched by a counter
    logic [BW-1:0] bound_q;
    logic          all_valid;
    assign all_valid = !any_rst && mclk_ok && clocks_ok && ratio_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q <= '0;
        end else if (all_valid && (state_o == ST_PDN || state_o == ST_INIT || state_o == ST_PUP)) begin
            if (bound_q != BW'(MAX_START_CYC)) bound_q <= bound_q + 1'b1;
        end else begin
            bound_q <= '0;
        end
    end

    p_start_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bound_q < BW'(MAX_START_CYC));

endmodule

// File: tb/dac_pwr_seq_bench.sv
module dac_pwr_seq_bench;
    localparam int GAP  = 8;
    localparam int MAXS = 64;
    localparam int SW   = 24;
    localparam int ZRUN = 8192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_rst_n = 1'b0, por_rst = 1'b0;
    logic          mclk_ok = 1'b0, clocks_ok = 1'b0, ratio_ok = 1'b0, ratio_chg = 1'b0;
    logic          sample_valid = 1'b0;
    logic [SW-1:0] sample_data = '0;
    logic [2:0]    state_o;
    logic          cp_en, filt_en, ref_up, out_clamp, amp_en, ref_tie, mute, zeros_ok;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    dac_pwr_seq #(
        .GAP_CYC (GAP), .MAX_START_CYC (MAXS), .SAMPLE_W (SW), .ZERO_RUN (ZRUN)
    ) u_dac_pwr_seq (
        .clk (clk), .rst_n (rst_n), .ext_rst_n (ext_rst_n), .por_rst (por_rst),
        .mclk_ok (mclk_ok), .clocks_ok (clocks_ok), .ratio_ok (ratio_ok),
        .ratio_chg (ratio_chg), .sample_valid (sample_valid), .sample_data (sample_data),
        .state_o (state_o), .cp_en (cp_en), .filt_en (filt_en), .ref_up (ref_up),
        .out_clamp (out_clamp), .amp_en (amp_en), .ref_tie (ref_tie), .mute (mute),
        .zeros_ok (zeros_ok)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic to_norm();
        ext_rst_n = 1; por_rst = 0; mclk_ok = 1; clocks_ok = 1; ratio_ok = 1; ratio_chg = 0;
        for (int i = 0; i < 200 && state_o != 3'd4; i++) tick();
        chk("R5 reach normal", state_o, 4);
    endtask

    task automatic t_reset_state();
        chk("R1 state", state_o, 0);
        chk("R1 ref_tie", ref_tie, 1);
        chk("R1 clamp", out_clamp, 1);
        chk("R1 mute", mute, 1);
        chk("R1 cp_en", cp_en, 0);
        chk("R1 amp_en", amp_en, 0);
        chk("R11 zeros_ok reset", zeros_ok, 0);
    endtask

    task automatic t_bringup_stepped();
        ext_rst_n = 1; tick();
        chk("R2 enter pdn", state_o, 1);
        chk("R2 ref_tie off", ref_tie, 0);
        tick(5);
        chk("R2 hold pdn", state_o, 1);
        chk("R2 cp off", cp_en, 0);
        mclk_ok = 1; tick();
        chk("R3 init", state_o, 2);
        chk("R3 cp on", cp_en, 1);
        chk("R3 filt off", filt_en, 0);
        ratio_ok = 1; tick(3);
        chk("R4 wait clocks", state_o, 2);
        clocks_ok = 1; tick();
        chk("R4 power-up", state_o, 3);
        chk("R5 filt at entry", filt_en, 0);
        tick(GAP - 1);
        chk("R5 filt before gap", filt_en, 0);
        tick();
        chk("R5 filt on", filt_en, 1);
        chk("R5 ref still off", ref_up, 0);
        tick(GAP);
        chk("R5 ref on", ref_up, 1);
        chk("R5 clamp still on", out_clamp, 1);
        tick(GAP);
        chk("R5 clamp off", out_clamp, 0);
        chk("R5 amp still off", amp_en, 0);
        chk("R6 muted in pup", mute, 1);
        tick(GAP);
        chk("R5 amp on", amp_en, 1);
        chk("R5 still pup", state_o, 3);
        tick();
        chk("R5 normal", state_o, 4);
        chk("R6 unmuted", mute, 0);
    endtask

    task automatic t_start_bound();
        int n;
        ext_rst_n = 0; tick();
        mclk_ok = 1; clocks_ok = 1; ratio_ok = 1; ratio_chg = 0; ext_rst_n = 1;
        n = 0;
        for (int i = 0; i < 200 && state_o != 3'd4; i++) begin tick(); n++; end
        chk("R10 bring-up edges", n, 4 * GAP + 4);
        chk("R10 under budget", (n < MAXS) ? 1 : 0, 1);
    endtask

    task automatic t_ratio_mute();
        ratio_chg = 1; tick(); ratio_chg = 0;
        chk("R7 mute state", state_o, 5);
        chk("R7 mute", mute, 1);
        chk("R7 amp held", amp_en, 1);
        chk("R6 clamp off in mute", out_clamp, 0);
        tick();
        chk("R8 back to normal", state_o, 4);
        ratio_ok = 0; tick();
        chk("R7 bad ratio mute", state_o, 5);
        tick(3);
        chk("R8 stays mute", state_o, 5);
        ratio_ok = 1; tick();
        chk("R8 normal again", state_o, 4);
        chk("R8 unmute", mute, 0);
    endtask

    task automatic t_mclk_loss();
        mclk_ok = 0; tick();
        chk("R9 pdn", state_o, 1);
        chk("R9 cp off", cp_en, 0);
        chk("R9 amp off", amp_en, 0);
        chk("R9 clamp on", out_clamp, 1);
        chk("R9 muted", mute, 1);
        to_norm();
        mclk_ok = 0; ratio_ok = 0; tick();
        chk("R9 from mute path", state_o, 1);
    endtask

    task automatic t_priority();
        to_norm();
        ratio_chg = 1; mclk_ok = 0; tick(); ratio_chg = 0;
        chk("R12 clock loss over ratio", state_o, 1);
        chk("R12 amp off", amp_en, 0);
        to_norm();
        ext_rst_n = 0; mclk_ok = 0; tick();
        chk("R12 reset over clock loss", state_o, 0);
        chk("R12 ref_tie", ref_tie, 1);
        to_norm();
        por_rst = 1; tick();
        chk("R1 por reset", state_o, 0);
        tick(3);
        chk("R1 por holds", state_o, 0);
        por_rst = 0; tick();
        chk("R2 leave reset", state_o, 1);
    endtask

    task automatic send_zeros(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            sample_valid = 1; sample_data = '0; tick();
            if (gaps) begin sample_valid = 0; sample_data = 24'h00_0F00; tick(); end
        end
        sample_valid = 0;
    endtask

    task automatic t_zero_run();
        send_zeros(ZRUN - 1, 0);
        chk("R11 one short", zeros_ok, 0);
        send_zeros(1, 0);
        chk("R11 full run", zeros_ok, 1);
        sample_valid = 0; sample_data = 24'h12_3456; tick(3);
        chk("R11 idle nonzero ignored", zeros_ok, 1);
        sample_valid = 1; sample_data = 24'h80_0000; tick(); sample_valid = 0;
        chk("R11 nonzero clears", zeros_ok, 0);
        send_zeros(5000, 0);
        sample_valid = 1; sample_data = 24'h00_0001; tick(); sample_valid = 0;
        send_zeros(ZRUN - 1, 0);
        chk("R11 restart after nonzero", zeros_ok, 0);
        send_zeros(1, 0);
        chk("R11 restart complete", zeros_ok, 1);
        sample_valid = 1; sample_data = 24'hFF_FFFF; tick(); sample_valid = 0;
        send_zeros(ZRUN, 1);
        chk("R11 run with idle gaps", zeros_ok, 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        t_reset_state();
        t_bringup_stepped();
        t_ratio_mute();
        t_mclk_loss();
        t_start_bound();
        t_priority();
        t_zero_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule